// File: doc/BRIEF.md
# Saturating Arithmetic Shift Unit

This block is the arithmetic shifter of a DSP datapath. It shifts one of three operand sizes: a 16-bit lane picked from a 32-bit source, a full 32-bit word, or a 40-bit accumulator. The shift count is signed. A positive count shifts left and a negative count shifts right arithmetically by its magnitude. The count comes either from a signed 8-bit immediate field or from a 16-bit count register, and it is clamped to plus or minus the operand width.

Left shifts of lanes and words can optionally saturate. When a shifted value no longer fits, the result clamps to the most positive or most negative value of the operand size, and an overflow flag is raised. In lane mode the shifted 16-bit result is written into the high or low half of the destination word, and the other half is copied from the old destination value. The result and the flag are registered, so they appear one clock after the inputs are presented.

Top module: `sas_shift_unit`

## Requirements
- R1: A negative count shifts the operand right arithmetically by the count's magnitude, refilling the top with copies of the sign bit; a lane value of -64 with count -4 gives -4.
- R2: Counts beyond the operand width are clamped to plus or minus the width, so a right shift by the width or more yields all sign bits (0 or all ones), and a left shift by the width or more leaves zero when not saturating.
- R3: With `sat_i` = 0, a left shift drops the bits that leave the top, fills the bottom with zeros, and leaves `ovf_o` at 0.
- R4: With `sat_i` = 1, a lane or word left shift whose result does not fit clamps to the most positive value (0x7FFF / 0x7FFFFFFF) for a non-negative input and to the most negative value (0x8000 / 0x80000000) for a negative input, with `ovf_o` = 1; a result that fits is exact and leaves `ovf_o` at 0.
- R5: With `use_imm_i` = 1 the count is `imm_i` read as signed 8-bit; with `use_imm_i` = 0 the count is `cnt_reg_i` read as signed 16-bit.
- R6: `size_i` encodes the operand: 2'b00 is a 16-bit lane, 2'b01 is a 32-bit word, 2'b10 is the 40-bit accumulator, and 2'b11 behaves as a word.
- R7: In lane mode, `src_hi_i` = 1 takes bits 31:16 of `src_i` as the operand, and `src_hi_i` = 0 takes bits 15:0.
- R8: In lane mode, `dst_hi_i` = 1 places the 16-bit result in bits 31:16 and copies bits 15:0 from `dst_old_i`; `dst_hi_i` = 0 places the result in bits 15:0 and copies bits 31:16.
- R9: Accumulator shifts never saturate: left shifts wrap modulo 2^40 and `ovf_o` stays 0, even when `sat_i` = 1.
- R10: For lane and word operations, bits 39:32 of `res_o` are copies of bit 31.
- R11: `res_o` and `ovf_o` are registered with one clock of latency, and a synchronous active-high `rst` clears both to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_i | input | 2 | Operand size select (00 lane, 01 word, 10 accumulator, 11 word) |
| sat_i | input | 1 | Saturate left shifts of lanes and words |
| use_imm_i | input | 1 | 1 selects the immediate count, 0 the register count |
| imm_i | input | 8 | Signed immediate shift count |
| cnt_reg_i | input | 16 | Signed register shift count |
| src_i | input | 40 | Source operand; the accumulator uses all bits, words and lanes use bits 31:0 |
| dst_old_i | input | 32 | Previous destination word, merged in lane mode |
| src_hi_i | input | 1 | Lane mode: take the upper source half |
| dst_hi_i | input | 1 | Lane mode: write the upper destination half |
| res_o | output | 40 | Registered shift result |
| ovf_o | output | 1 | Registered flag: saturation clamped the result |

## Verification
Saturation and lane merging can take effect in the same operation. A saturating left shift of a 16-bit lane clamps that lane while the other half of the destination is copied from the old value. The bench provokes this by sweeping every count from beyond minus the width to beyond plus the width over extreme lane values (0x7FFF, 0x8000, -1, 0x4000). Each sweep runs in all four source and destination half combinations, with the old destination and the unused source half holding distinct patterns. Each result is judged against an arithmetic model that computes the shifted value in 64-bit signed arithmetic. The model clamps it against the lane range and then rebuilds the full 40-bit word, so a clamp that disturbs the untouched half, or a merge that hides a clamp, shows up as a mismatch.

// File: rtl/sas_pkg.sv
package sas_pkg;
  typedef enum logic [1:0] {
    SZ_LANE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_ACC  = 2'b10,
    SZ_ALTW = 2'b11
  } sas_size_e;
endpackage

// File: rtl/sas_count_norm.sv
// Picks the count source and clamps it to +/- the operand width.
module sas_count_norm #(
  parameter int CNT_W = 16,
  parameter int IMM_W = 8,
  parameter int SHW   = 7
) (
  input  logic             use_imm,
  input  logic [IMM_W-1:0] imm,
  input  logic [CNT_W-1:0] reg_cnt,
  input  logic [SHW-1:0]   limit,
  output logic [SHW-1:0]   cnt
);
  localparam int EW = CNT_W + 1;

  logic signed [EW-1:0] raw_e;
  logic signed [EW-1:0] lim_p;
  logic signed [EW-1:0] lim_n;
  logic signed [EW-1:0] sel;

  always_comb begin
    if (use_imm) raw_e = EW'($signed(imm));
    else         raw_e = EW'($signed(reg_cnt));
    lim_p = $signed({{(EW-SHW){1'b0}}, limit});
    lim_n = -lim_p;
    if (raw_e > lim_p)      sel = lim_p;
    else if (raw_e < lim_n) sel = lim_n;
    else                    sel = raw_e;
    cnt = SHW'(sel);
  end
endmodule

// File: rtl/sas_shift_core.sv
// Signed-count arithmetic shifter of one width with optional clamping.
module sas_shift_core #(
  parameter int W   = 16,
  parameter int SHW = 7
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] cnt,
  input  logic           sat,
  output logic [W-1:0]   y,
  output logic           ovf
);
  logic           neg;
  logic [SHW-1:0] mag;
  logic [2*W-1:0] wide;
  logic [W:0]     top;
  logic           lost;
  logic [W-1:0]   pos_lim;
  logic [W-1:0]   neg_lim;

  always_comb begin
    neg     = cnt[SHW-1];
    mag     = neg ? SHW'(-cnt) : cnt;
    wide    = {{W{a[W-1]}}, a} << mag;
    top     = wide[2*W-1:W-1];
    lost    = !neg && !((top == '0) || (top == '1));
    pos_lim = {1'b0, {(W-1){1'b1}}};
    neg_lim = {1'b1, {(W-1){1'b0}}};
    ovf     = 1'b0;
    if (neg) begin
      y = $signed(a) >>> mag;
    end else if (lost && sat) begin
      y   = a[W-1] ? neg_lim : pos_lim;
      ovf = 1'b1;
    end else begin
      y = wide[W-1:0];
    end
  end
endmodule

// File: rtl/sas_lane_merge.sv
// Writes a 16-bit lane into one half of the old destination word.
module sas_lane_merge #(
  parameter int HW = 16
) (
  input  logic            dst_hi,
  input  logic [2*HW-1:0] old,
  input  logic [HW-1:0]   lane,
  output logic [2*HW-1:0] y
);
  assign y = dst_hi ? {lane, old[HW-1:0]} : {old[2*HW-1:HW], lane};
endmodule

// File: rtl/sas_shift_unit.sv
module sas_shift_unit
  import sas_pkg::*;
#(
  parameter int HW    = 16,
  parameter int WW    = 32,
  parameter int AW    = 40,
  parameter int CNT_W = 16,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_i,
  input  logic             sat_i,
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [CNT_W-1:0] cnt_reg_i,
  input  logic [AW-1:0]    src_i,
  input  logic [WW-1:0]    dst_old_i,
  input  logic             src_hi_i,
  input  logic             dst_hi_i,
  output logic [AW-1:0]    res_o,
  output logic             ovf_o
);
  localparam int SHW = $clog2(AW + 1) + 1;
  localparam int XW  = AW - WW;

  sas_size_e      size_e;
  logic [SHW-1:0] limit;
  logic [SHW-1:0] cnt;
  logic [HW-1:0]  lane_src;
  logic [HW-1:0]  lane_y;
  logic [WW-1:0]  word_y;
  logic [AW-1:0]  acc_y;
  logic [WW-1:0]  merged;
  logic           lane_ovf;
  logic           word_ovf;
  logic           acc_ovf;
  logic [AW-1:0]  nxt_res;
  logic           nxt_ovf;
  logic [AW-1:0]  res_q;
  logic           ovf_q;

  assign size_e = sas_size_e'(size_i);

  always_comb begin
    case (size_e)
      SZ_LANE: limit = SHW'(HW);
      SZ_ACC:  limit = SHW'(AW);
      default: limit = SHW'(WW);
    endcase
  end

  sas_count_norm #(.CNT_W(CNT_W), .IMM_W(IMM_W), .SHW(SHW)) cnt_i (
    .use_imm (use_imm_i),
    .imm     (imm_i),
    .reg_cnt (cnt_reg_i),
    .limit   (limit),
    .cnt     (cnt)
  );

  assign lane_src = src_hi_i ? src_i[2*HW-1:HW] : src_i[HW-1:0];

  sas_shift_core #(.W(HW), .SHW(SHW)) lane_core_i (
    .a (lane_src), .cnt (cnt), .sat (sat_i), .y (lane_y), .ovf (lane_ovf)
  );

  sas_shift_core #(.W(WW), .SHW(SHW)) word_core_i (
    .a (src_i[WW-1:0]), .cnt (cnt), .sat (sat_i), .y (word_y), .ovf (word_ovf)
  );

  // Accumulator path always wraps: saturation is tied off.
  sas_shift_core #(.W(AW), .SHW(SHW)) acc_core_i (
    .a (src_i), .cnt (cnt), .sat (1'b0), .y (acc_y), .ovf (acc_ovf)
  );

  sas_lane_merge #(.HW(HW)) merge_i (
    .dst_hi (dst_hi_i),
    .old    (dst_old_i),
    .lane   (lane_y),
    .y      (merged)
  );

  always_comb begin
    case (size_e)
      SZ_LANE: begin
        nxt_res = {{XW{merged[WW-1]}}, merged};
        nxt_ovf = lane_ovf;
      end
      SZ_ACC: begin
        nxt_res = acc_y;
        nxt_ovf = acc_ovf;
      end
      default: begin
        nxt_res = {{XW{word_y[WW-1]}}, word_y};
        nxt_ovf = word_ovf;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      res_q <= nxt_res;
      ovf_q <= nxt_ovf;
    end
  end

  assign res_o = res_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/sas_shift_unit_chk.sv
module sas_shift_unit_chk #(
  parameter int HW = 16,
  parameter int WW = 32,
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    size_i,
  input logic          sat_i,
  input logic [WW-1:0] dst_old_i,
  input logic          dst_hi_i,
  input logic [AW-1:0] res_o,
  input logic          ovf_o
);
  localparam logic [HW-1:0] LMAX = {1'b0, {(HW-1){1'b1}}};
  localparam logic [HW-1:0] LMIN = {1'b1, {(HW-1){1'b0}}};
  localparam logic [WW-1:0] WMAX = {1'b0, {(WW-1){1'b1}}};
  localparam logic [WW-1:0] WMIN = {1'b1, {(WW-1){1'b0}}};

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !ovf_o));

  p_no_ovf_nosat_r3: assert property (@(posedge clk) disable iff (rst)
    !sat_i |=> !ovf_o);

  p_no_ovf_acc_r9: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b10) |=> !ovf_o);

  p_keep_low_r8: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b00 && dst_hi_i) |=> (res_o[HW-1:0] == $past(dst_old_i[HW-1:0])));

  p_keep_high_r8: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b00 && !dst_hi_i) |=> (res_o[WW-1:HW] == $past(dst_old_i[WW-1:HW])));

  p_word_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (size_i[1] == 1'b0 && size_i[0] == 1'b1) |=>
      (!ovf_o || res_o[WW-1:0] == WMAX || res_o[WW-1:0] == WMIN));

  p_lane_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    (size_i == 2'b00 && dst_hi_i) |=>
      (!ovf_o || res_o[WW-1:HW] == LMAX || res_o[WW-1:HW] == LMIN));

  p_sign_ext_r10: assert property (@(posedge clk) disable iff (rst)
    (size_i != 2'b10) |=> (res_o[AW-1:WW] == {(AW-WW){res_o[WW-1]}}));
endmodule

bind sas_shift_unit sas_shift_unit_chk #(.HW(HW), .WW(WW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .size_i    (size_i),
  .sat_i     (sat_i),
  .dst_old_i (dst_old_i),
  .dst_hi_i  (dst_hi_i),
  .res_o     (res_o),
  .ovf_o     (ovf_o)
);

// File: tb/sas_shift_unit_tb.sv
module sas_shift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  size_i = 2'b00;
  logic        sat_i = 1'b0;
  logic        use_imm_i = 1'b0;
  logic [7:0]  imm_i = '0;
  logic [15:0] cnt_reg_i = '0;
  logic [39:0] src_i = '0;
  logic [31:0] dst_old_i = '0;
  logic        src_hi_i = 1'b0;
  logic        dst_hi_i = 1'b0;
  logic [39:0] res_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sas_shift_unit dut_i (
    .clk (clk), .rst (rst), .size_i (size_i), .sat_i (sat_i),
    .use_imm_i (use_imm_i), .imm_i (imm_i), .cnt_reg_i (cnt_reg_i),
    .src_i (src_i), .dst_old_i (dst_old_i), .src_hi_i (src_hi_i),
    .dst_hi_i (dst_hi_i), .res_o (res_o), .ovf_o (ovf_o)
  );

  task automatic check(input string req, input logic [39:0] got_r, input bit got_o,
                       input logic [39:0] exp_r, input bit exp_o);
    checks++;
    if (got_r !== exp_r || got_o !== exp_o) begin
      errors++;
      $display("FAIL %s: res=%h ovf=%0b expected res=%h ovf=%0b",
               req, got_r, got_o, exp_r, exp_o);
    end
  endtask

  function automatic void model(input int sz, input logic [39:0] src, input logic [31:0] old,
                                input int cnt, input bit sat, input bit shi, input bit dhi,
                                output logic [39:0] r, output bit ov);
    int w;
    int c;
    longint v, mx, mn, p;
    logic [63:0] u;
    logic [31:0] w32;
    w = (sz == 0) ? 16 : ((sz == 2) ? 40 : 32);
    if (sz == 0) v = shi ? longint'($signed(src[31:16])) : longint'($signed(src[15:0]));
    else if (sz == 2) v = longint'($signed(src[39:0]));
    else v = longint'($signed(src[31:0]));
    c = (cnt > w) ? w : ((cnt < -w) ? -w : cnt);
    mx = (64'sd1 <<< (w - 1)) - 1;
    mn = -mx - 1;
    ov = 1'b0;
    if (c >= 0) begin
      p = v <<< c;
      if (sz != 2 && sat && (p > mx || p < mn)) begin
        ov = 1'b1;
        p = (v < 0) ? mn : mx;
      end
    end else begin
      p = v >>> (-c);
    end
    u = p;
    if (sz == 0) begin
      w32 = dhi ? {u[15:0], old[15:0]} : {old[31:16], u[15:0]};
      r = {{8{w32[31]}}, w32};
    end else if (sz == 2) begin
      r = u[39:0];
    end else begin
      w32 = u[31:0];
      r = {{8{w32[31]}}, w32};
    end
  endfunction

  task automatic run(input string req, input int sz, input logic [39:0] src,
                     input logic [31:0] old, input int cnt, input bit imm,
                     input bit sat, input bit shi, input bit dhi);
    logic [39:0] er;
    bit eo;
    @(negedge clk);
    size_i = sz[1:0];
    sat_i = sat;
    use_imm_i = imm;
    imm_i = imm ? cnt[7:0] : 8'h5A;
    cnt_reg_i = imm ? 16'hA5C3 : cnt[15:0];
    src_i = src;
    dst_old_i = old;
    src_hi_i = shi;
    dst_hi_i = dhi;
    @(posedge clk);
    #1;
    model(sz, src, old, cnt, sat, shi, dhi, er, eo);
    check(req, res_o, ovf_o, er, eo);
  endtask

  function automatic string tag(input int sz, input int cnt, input bit sat);
    if (sz == 2) return "R9";
    if (cnt < 0) return "R1";
    if (sat) return "R4";
    return "R3";
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lv [8];
    logic [31:0] wv [8];
    logic [39:0] av [8];
    lv = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0123, 16'hFFC0, 16'h4000};
    wv = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h12345678,
           32'hFFFFFFC0, 32'h40000000};
    av = '{40'h0, 40'h1, 40'hFFFFFFFFFF, 40'h7FFFFFFFFF, 40'h8000000000,
           40'h123456789A, 40'hFFFFFFFFC0, 40'h4000000001};

    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", res_o, ovf_o, 40'h0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R1 directed: lane -64 right by 4 gives -4, written into high half.
    run("R1 -64>>>4", 0, {8'h00, 16'hFFC0, 16'h1111}, 32'hDEAD_BEEF, -4, 1, 0, 1, 1);
    // R2: huge register counts clamp to the width.
    run("R2 right clamp", 1, {8'h0, 32'h80000001}, 32'h0, -32768, 0, 0, 0, 0);
    run("R2 left clamp", 1, {8'h0, 32'h00000001}, 32'h0, 32767, 0, 0, 0, 0);
    run("R2 acc right clamp", 2, 40'h8000000000, 32'h0, -300, 0, 0, 0, 0);
    // R5: immediate vs register sources.
    run("R5 imm", 1, {8'h0, 32'h00000003}, 32'h0, 12, 1, 0, 0, 0);
    run("R5 reg", 1, {8'h0, 32'h00000003}, 32'h0, 24, 0, 0, 0, 0);
    // R6: code 11 behaves as word.
    run("R6 size11", 3, {8'h77, 32'h40000000}, 32'h0, 1, 1, 1, 0, 0);
    // R10: sign extension of word result.
    run("R10 ext", 1, {8'h00, 32'h40000000}, 32'h0, 1, 1, 0, 0, 0);

    // R11 latency: new inputs do not show before the next edge.
    @(negedge clk);
    size_i = 2'b01; sat_i = 1'b0; use_imm_i = 1'b1; imm_i = 8'd0;
    src_i = 40'h00_0000_1234;
    #1;
    check("R11 latency hold", res_o, ovf_o, 40'hFF_8000_0000, 1'b0);
    @(posedge clk);
    #1;
    check("R11 latency update", res_o, ovf_o, 40'h00_0000_1234, 1'b0);

    // Lane sweep: R7/R8 combined with R1/R3/R4 and count clamping.
    for (int vi = 0; vi < 8; vi++)
      for (int c = -19; c <= 19; c++)
        for (int s = 0; s < 2; s++)
          for (int hs = 0; hs < 4; hs++) begin
            logic [15:0] other;
            logic [39:0] src;
            other = 16'hA55A ^ 16'(vi * 37);
            src = hs[0] ? {8'h3C, lv[vi], other} : {8'h3C, other, lv[vi]};
            run({tag(0, c, s[0]), " R7 R8 lane"}, 0, src, 32'h1357_9BDF ^ 32'(vi),
                c, ((c + vi) % 2) == 0, s[0], hs[0], hs[1]);
          end

    // Word sweep.
    for (int vi = 0; vi < 8; vi++)
      for (int c = -35; c <= 35; c++)
        for (int s = 0; s < 2; s++)
          run({tag(1, c, s[0]), " word"}, 1, {8'hC3, wv[vi]}, 32'h0,
              c, ((c + vi) % 2) != 0, s[0], 0, 0);

    // Accumulator sweep: saturate flag requested but must have no effect.
    for (int vi = 0; vi < 8; vi++)
      for (int c = -43; c <= 43; c++)
        run({tag(2, c, 1'b1), " acc"}, 2, av[vi], 32'h0,
            c, ((c + vi) % 2) == 0, 1'b1, 0, 0);

    // R11: synchronous reset clears a non-zero result.
    run("R4 pre-reset", 0, {8'h0, 16'h0, 16'h7FFF}, 32'h0, 3, 1, 1, 0, 0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R11 reset clear", res_o, ovf_o, 40'h0, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule